// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block recovers asynchronous serial characters from a single line. It samples the line on a tick that runs at 16 times the bit rate. A 16-bit divisor sets that tick. The block validates the start bit at mid-bit and then samples each data bit, the optional parity bit and the first stop bit at their centres. Word length (5 to 8 bits), parity enable and parity sense are programmable. A loop-back select makes the receiver listen to the local transmitter output instead of the external pin.

Each recovered character is stored with its own parity-error, framing-error and break flags. Storage is a 64-entry queue when buffered mode is on, and a single holding slot when it is off. Changing the mode flushes any stored characters. Characters leave through a valid/ready stream. The head entry, together with its flags, is presented while `rd_valid` is high and is removed on a cycle where `rd_valid` and `rd_ready` are both high. The consumer may hold `rd_ready` low for as long as it likes. While it does, the head does not change, and characters that arrive after the storage is full are dropped and recorded as an overrun. One interrupt request combines a data-available condition and a line-error condition, each gated by its own enable.

Top module: `serial_rx_top`

## Requirements
- R1: With divisor N (0 treated as 1) the sampling tick occurs once every N clocks, and a frame with bits held 16 ticks each is recovered least significant bit first.
- R2: `word_len` codes 0,1,2,3 select 5,6,7,8 data bits; the bits of `rd_data` above the word length read zero.
- R3: While `rd_valid` is high and `rd_ready` is low, the head data and flags hold steady, and characters are delivered in arrival order.
- R4: With `parity_en` high, one parity bit follows the data; `parity_odd`=1 expects an odd total count of ones over data and parity, 0 expects an even count, and a mismatch sets `rd_perr` for that character.
- R5: A stop bit sampled low sets `rd_ferr` for that character.
- R6: A frame in which start, data, parity (if enabled) and stop bits all read zero sets `rd_brk` together with `rd_ferr`; the receiver then waits for the line to return high before seeking a new start bit.
- R7: A low pulse that has ended by the mid-start sample (8 ticks after the falling edge is seen) produces no character.
- R8: With `loopback` high, `tx_loop` feeds the receiver and activity on `rx_serial` has no effect; with it low, `rx_serial` is used.
- R9: In buffered mode (`fifo_en`=1), up to 64 characters are held without loss.
- R10: A character that completes while storage is full (64 entries buffered, 1 entry unbuffered) is discarded and sets `overrun`, which stays set until an `ovr_clr` pulse.
- R11: `irq_req` is high when `irq_data_en` is set and a character is available, or when `irq_line_en` is set and `overrun` is set or the head entry carries an error flag; with both enables low it stays low.
- R12: `rd_perr`, `rd_ferr` and `rd_brk` show the flags of the head entry only and read zero when nothing is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_div | input | 16 | Clocks per sampling tick (0 acts as 1) |
| word_len | input | 2 | Data bits minus five |
| parity_en | input | 1 | Parity bit present |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| fifo_en | input | 1 | 1 = 64-entry queue, 0 = single slot |
| loopback | input | 1 | Select `tx_loop` as the receive source |
| rx_serial | input | 1 | External serial line, idle high |
| tx_loop | input | 1 | Local transmitter output for loop-back |
| rd_valid | output | 1 | A character is available |
| rd_ready | input | 1 | Consumer accepts the head character |
| rd_data | output | 8 | Head character data |
| rd_perr | output | 1 | Head parity error |
| rd_ferr | output | 1 | Head framing error |
| rd_brk | output | 1 | Head break indication |
| overrun | output | 1 | Sticky overrun flag |
| ovr_clr | input | 1 | Pulse to clear `overrun` |
| irq_data_en | input | 1 | Enable data-available interrupt |
| irq_line_en | input | 1 | Enable line-error interrupt |
| irq_req | output | 1 | Interrupt request |

## Verification
The stream-stability property assumes that `fifo_en` is changed only while `rd_ready` is irrelevant, so it is checked only across cycles in which the mode is stable. The bench changes the mode only while the storage is empty. The properties also assume that framing settings stay fixed while a frame is on the line. The bench programs word length, parity and divisor only between frames, after the line has been idle high for at least two bit times. Bench frames hold each bit for exactly 16 ticks, so every centre sample lands well inside its bit.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       perr;
    logic [7:0] data;
  } rx_char_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_HOLD
  } rx_state_e;

endpackage

// File: rtl/serial_rx_tick.sv
module serial_rx_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim = (div == '0) ? '0 : div - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_rx_framer.sv
module serial_rx_framer
  import serial_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     line,
  input  logic [1:0] word_len,
  input  logic     parity_en,
  input  logic     parity_odd,
  output logic     chr_vld,
  output rx_char_t chr
);
  localparam int TW = $clog2(OVS);
  localparam logic [TW-1:0] MID  = TW'(OVS / 2 - 1);
  localparam logic [TW-1:0] FULL = TW'(OVS - 1);

  rx_state_e  st;
  logic [TW-1:0] tcnt;
  logic [2:0] bidx;
  logic [7:0] shreg;
  logic       pbit;
  logic [2:0] last_idx;

  assign last_idx = 3'd4 + {1'b0, word_len};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      tcnt    <= '0;
      bidx    <= '0;
      shreg   <= '0;
      pbit    <= 1'b0;
      chr_vld <= 1'b0;
      chr     <= '0;
    end else begin
      chr_vld <= 1'b0;
      if (tick) begin
        case (st)
          ST_IDLE: begin
            if (!line) begin
              st   <= ST_START;
              tcnt <= '0;
            end
          end
          ST_START: begin
            if (tcnt == MID) begin
              tcnt <= '0;
              if (!line) begin
                st    <= ST_DATA;
                bidx  <= '0;
                shreg <= '0;
                pbit  <= 1'b0;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (tcnt == FULL) begin
              tcnt        <= '0;
              shreg[bidx] <= line;
              if (bidx == last_idx) st <= parity_en ? ST_PAR : ST_STOP;
              else                  bidx <= bidx + 1'b1;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          ST_PAR: begin
            if (tcnt == FULL) begin
              tcnt <= '0;
              pbit <= line;
              st   <= ST_STOP;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (tcnt == FULL) begin
              tcnt      <= '0;
              chr_vld   <= 1'b1;
              chr.data  <= shreg;
              chr.perr  <= parity_en & ((^shreg) ^ pbit ^ parity_odd);
              chr.ferr  <= ~line;
              chr.brk   <= ~line & (shreg == '0) & (~parity_en | ~pbit);
              st        <= line ? ST_IDLE : ST_HOLD;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          ST_HOLD: begin
            if (line) st <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_rx_store.sv
module serial_rx_store
  import serial_rx_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fifo_en,
  input  logic     push,
  input  rx_char_t push_chr,
  input  logic     pop,
  input  logic     ovr_clr,
  output logic     valid,
  output rx_char_t head,
  output logic     overrun
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  rx_char_t      mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          mode_q;
  logic          full, flush, do_push, do_pop;

  assign full    = fifo_en ? (cnt == CW'(DEPTH)) : (cnt != '0);
  assign flush   = (mode_q != fifo_en);
  assign valid   = (cnt != '0);
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & valid & ~flush;
  assign head    = valid ? mem[rp] : '0;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_chr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      mode_q  <= 1'b1;
      overrun <= 1'b0;
    end else begin
      mode_q <= fifo_en;
      if (flush) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
        if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
        case ({do_push, do_pop})
          2'b10:   cnt <= cnt + 1'b1;
          2'b01:   cnt <= cnt - 1'b1;
          default: cnt <= cnt;
        endcase
      end
      if (push & full)  overrun <= 1'b1;
      else if (ovr_clr) overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_rx_top.sv
module serial_rx_top
  import serial_rx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int DEPTH = 64,
  parameter int OVS   = 16,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [1:0]       word_len,
  input  logic             parity_en,
  input  logic             parity_odd,
  input  logic             fifo_en,
  input  logic             loopback,
  input  logic             rx_serial,
  input  logic             tx_loop,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             rd_perr,
  output logic             rd_ferr,
  output logic             rd_brk,
  output logic             overrun,
  input  logic             ovr_clr,
  input  logic             irq_data_en,
  input  logic             irq_line_en,
  output logic             irq_req
);
  logic [SYNC-1:0] sync_q;
  logic            line, tick, chr_vld;
  rx_char_t        chr, head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC-2:0], (loopback ? tx_loop : rx_serial)};
  end
  assign line = sync_q[SYNC-1];

  serial_rx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
  );

  serial_rx_framer #(.OVS(OVS)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line(line),
    .word_len(word_len), .parity_en(parity_en), .parity_odd(parity_odd),
    .chr_vld(chr_vld), .chr(chr)
  );

  serial_rx_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
    .push(chr_vld), .push_chr(chr), .pop(rd_ready), .ovr_clr(ovr_clr),
    .valid(rd_valid), .head(head), .overrun(overrun)
  );

  assign rd_data = head.data;
  assign rd_perr = head.perr;
  assign rd_ferr = head.ferr;
  assign rd_brk  = head.brk;

  assign irq_req = (irq_data_en & rd_valid)
                 | (irq_line_en & (overrun | rd_perr | rd_ferr | rd_brk));
endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_en,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       rd_perr,
  input logic       rd_ferr,
  input logic       rd_brk,
  input logic       overrun,
  input logic       ovr_clr,
  input logic       irq_data_en,
  input logic       irq_line_en,
  input logic       irq_req
);
  a_r3_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready && $stable(fifo_en) |=>
      rd_valid && $stable(rd_data) && $stable(rd_perr) && $stable(rd_ferr) && $stable(rd_brk));

  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !ovr_clr |=> overrun);

  a_r12_empty_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> !(rd_perr || rd_ferr || rd_brk));

  a_r6_break_framing: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_brk |-> rd_ferr);

  a_r11_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_data_en && !irq_line_en |-> !irq_req);
endmodule

bind serial_rx_top serial_rx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
  .overrun(overrun), .ovr_clr(ovr_clr),
  .irq_data_en(irq_data_en), .irq_line_en(irq_line_en), .irq_req(irq_req)
);

// File: tb/serial_rx_top_tb_top.sv
module serial_rx_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] baud_div = 16'd2;
  logic [1:0]  word_len = 2'd3;
  logic        parity_en = 1'b0, parity_odd = 1'b0, fifo_en = 1'b1, loopback = 1'b0;
  logic        rx_serial = 1'b1, tx_loop = 1'b1;
  logic        rd_ready = 1'b1, ovr_clr = 1'b0, irq_data_en = 1'b0, irq_line_en = 1'b0;
  logic        rd_valid, rd_perr, rd_ferr, rd_brk, overrun, irq_req;
  logic [7:0]  rd_data;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  logic [10:0] exp_q[$];   // {brk, ferr, perr, data}

  always #2 clk = ~clk;

  serial_rx_top dut_i (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .word_len(word_len),
    .parity_en(parity_en), .parity_odd(parity_odd), .fifo_en(fifo_en),
    .loopback(loopback), .rx_serial(rx_serial), .tx_loop(tx_loop),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
    .overrun(overrun), .ovr_clr(ovr_clr),
    .irq_data_en(irq_data_en), .irq_line_en(irq_line_en), .irq_req(irq_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every accepted transfer
  always @(negedge clk) begin
    cycles++;
    if (rst_n && rd_valid && rd_ready) begin
      if (exp_q.size() == 0) begin
        check("R3 unexpected character", {21'd0, rd_brk, rd_ferr, rd_perr, rd_data}, 32'h7ff);
      end else begin
        automatic logic [10:0] e = exp_q.pop_front();
        check("R1/R3 character and flags", {21'd0, rd_brk, rd_ferr, rd_perr, rd_data}, {21'd0, e});
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drive(input bit via_loop, input logic v);
    if (via_loop) tx_loop = v; else rx_serial = v;
  endtask

  // Driver: sends one frame and records the expected entry
  task automatic send(input logic [7:0] d, input bit badpar, input bit stopv,
                      input bit via_loop, input bit expect_it);
    automatic int nb = 5 + int'(word_len);
    automatic int bt = 16 * ((baud_div == 0) ? 1 : int'(baud_div));
    automatic logic [7:0] m = d & 8'((1 << nb) - 1);
    automatic logic pb = (^m) ^ parity_odd ^ badpar;
    automatic logic brk = (m == 0) && (!parity_en || !pb) && !stopv;
    if (expect_it) exp_q.push_back({brk, ~stopv, parity_en & badpar, m});
    drive(via_loop, 1'b0); step(bt);
    for (int i = 0; i < nb; i++) begin drive(via_loop, m[i]); step(bt); end
    if (parity_en) begin drive(via_loop, pb); step(bt); end
    drive(via_loop, stopv); step(bt);
    drive(via_loop, 1'b1); step(2 * bt);
  endtask

  initial begin
    step(5);
    check("R12 reset rd_valid", {31'd0, rd_valid}, 0);
    check("R10 reset overrun", {31'd0, overrun}, 0);
    check("R11 reset irq_req", {31'd0, irq_req}, 0);
    rst_n = 1'b1; step(5);

    // R1: 8N1 frames, divisor 2
    send(8'hA5, 0, 1, 0, 1);
    send(8'h3C, 0, 1, 0, 1);
    baud_div = 16'd0; step(4);   // R1: divisor 0 behaves as 1
    send(8'h81, 0, 1, 0, 1);
    baud_div = 16'd3; step(4);
    send(8'h5E, 0, 1, 0, 1);
    baud_div = 16'd2; step(4);

    // R2: short words, upper bits zero
    word_len = 2'd0; step(2); send(8'hF5, 0, 1, 0, 1);
    word_len = 2'd2; step(2); send(8'hFF, 0, 1, 0, 1);
    word_len = 2'd3; step(2);

    // R4: parity even/odd, good and bad
    parity_en = 1'b1; parity_odd = 1'b0; step(2);
    send(8'h07, 0, 1, 0, 1);
    send(8'h07, 1, 1, 0, 1);
    parity_odd = 1'b1; step(2);
    send(8'h03, 0, 1, 0, 1);
    send(8'h03, 1, 1, 0, 1);
    parity_en = 1'b0; step(2);

    // R5: framing error, R6: break then normal frame
    send(8'h55, 0, 0, 0, 1);
    send(8'h00, 0, 0, 0, 1);
    send(8'h42, 0, 1, 0, 1);
    check("R3 scoreboard drained", exp_q.size(), 0);

    // R7: short low glitch (3 ticks) gives nothing
    rx_serial = 1'b0; step(6); rx_serial = 1'b1; step(64);
    check("R7 glitch ignored", {31'd0, rd_valid}, 0);

    // R8: loopback source selection
    loopback = 1'b1; step(4);
    send(8'hC3, 0, 1, 1, 1);
    send(8'h00, 0, 0, 0, 0);       // external line ignored
    step(4);
    check("R8 rx_serial ignored in loopback", {31'd0, rd_valid}, 0);
    loopback = 1'b0; step(4);
    send(8'h00, 0, 0, 1, 0);       // tx_loop ignored when not in loopback
    step(4);
    check("R8 tx_loop ignored without loopback", {31'd0, rd_valid}, 0);

    // R12 + R3: head flags while holding, good then bad
    rd_ready = 1'b0;
    send(8'h11, 0, 1, 0, 1);
    send(8'h22, 0, 0, 0, 1);
    check("R12 head ferr is first entry", {31'd0, rd_ferr}, 0);
    check("R3 head data held", {24'd0, rd_data}, 32'h11);
    // R11: data interrupt
    irq_data_en = 1'b1; step(1);
    check("R11 data irq", {31'd0, irq_req}, 1);
    irq_data_en = 1'b0; step(1);
    check("R11 irq masked", {31'd0, irq_req}, 0);
    rd_ready = 1'b1; step(1); rd_ready = 1'b0; step(1);
    check("R12 head ferr of second entry", {31'd0, rd_ferr}, 1);
    irq_line_en = 1'b1; step(1);
    check("R11 line irq on head error", {31'd0, irq_req}, 1);
    irq_line_en = 1'b0;
    rd_ready = 1'b1; step(4);
    check("R12 flags zero when empty", {29'd0, rd_perr, rd_ferr, rd_brk}, 0);

    // R9/R10: fill 64 in buffered mode, 65th dropped
    baud_div = 16'd1; rd_ready = 1'b0; step(4);
    for (int i = 0; i < 65; i++) send(8'(i * 7 + 1), 0, 1, 0, i < 64);
    check("R10 overrun after 65th", {31'd0, overrun}, 1);
    irq_line_en = 1'b1; step(1);
    check("R11 line irq on overrun", {31'd0, irq_req}, 1);
    irq_line_en = 1'b0;
    rd_ready = 1'b1; step(80);
    check("R9 all 64 delivered", exp_q.size(), 0);
    check("R10 overrun sticky", {31'd0, overrun}, 1);
    ovr_clr = 1'b1; step(1); ovr_clr = 1'b0; step(1);
    check("R10 overrun cleared", {31'd0, overrun}, 0);

    // R10: unbuffered mode holds one character
    fifo_en = 1'b0; rd_ready = 1'b0; step(4);
    send(8'h9A, 0, 1, 0, 1);
    send(8'h6B, 0, 1, 0, 0);
    check("R10 single slot overrun", {31'd0, overrun}, 1);
    check("R10 single slot keeps first", {24'd0, rd_data}, 32'h9A);
    rd_ready = 1'b1; step(4);
    check("R10 single slot drained", exp_q.size(), 0);
    check("R10 single slot empty", {31'd0, rd_valid}, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule